// File: doc/BRIEF.md
# Converter Host Bus Read/Convert Interface

This block sits between a host bus and the core of a converter that produces a 12-bit result. It watches a chip-enable, an active-low chip-select and a read/convert level and turns them into one of two things. The first is a single-cycle convert-start strobe sent to the conversion sequencer. The second is a read cycle that places the stored result on a 12-bit data bus. Each data bit has its own output-enable, which stands in for a three-state driver.

A width strap selects the read format. The result can be presented as one 12-bit word, or packed for an 8-bit bus as two bytes on the upper eight lanes, with the byte chosen by an address bit. Tying enable and strap high and select and address low gives a stand-alone mode. In that mode the read/convert line alone paces conversions: while it is high the result is driven, and a falling edge starts a conversion.

The sequencer's busy flag blocks new starts and keeps the drivers off until the result is ready. A one-cycle warning pulse flags a cycle that opened with read/convert high, which is a likely bus contention. All outputs are registered and follow the inputs sampled at the previous clock edge.

Top module: `adc_bus_ctrl`

## Requirements
- R1: The interface is active only when `ce_i` is 1 and `cs_ni` is 0. While inactive, `data_oe_o` and `data_o` are all zero one cycle later and no start is issued.
- R2: `start_o` pulses for exactly one cycle after the edge at which the convert condition (active with `rd_cvt_i` = 0) first holds. The condition may be completed by `ce_i` rising, by `cs_ni` falling, or by `rd_cvt_i` falling.
- R3: Holding the convert condition for several cycles yields only one start pulse.
- R4: If `busy_i` is 1 at the edge where the convert condition begins, no start is issued, and none is issued later for that same condition.
- R5: With `wide_i` = 1, a read (active, `rd_cvt_i` = 1, `busy_i` = 0) sets all 12 enables to 1 and `data_o` equal to `result_i` one cycle later.
- R6: With `wide_i` = 0 and `addr_i` = 0, a read enables bits 11..4 only. Those bits carry `result_i[11:4]`, and bits 3..0 are 0.
- R7: With `wide_i` = 0 and `addr_i` = 1, a read enables bits 11..4 only. Bits 11..8 carry `result_i[3:0]`, and bits 7..0 are 0.
- R8: While `busy_i` is 1 no bit is enabled, even with read asserted. After a low-pulse start, the outputs are driven again only once busy falls.
- R9: `contention_o` pulses for one cycle when the active condition begins with `rd_cvt_i` = 1.
- R10: In stand-alone mode (`ce_i` = 1, `wide_i` = 1, `cs_ni` = 0, `addr_i` = 0), a high `rd_cvt_i` drives the full word. A falling `rd_cvt_i` issues a start and turns the drivers off on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Chip enable, active high |
| cs_ni | input | 1 | Chip select, active low |
| rd_cvt_i | input | 1 | 1 = read, 0 = convert |
| addr_i | input | 1 | Byte select for 8-bit packing |
| wide_i | input | 1 | 1 = single 12-bit word, 0 = two bytes |
| busy_i | input | 1 | Conversion in progress, from sequencer |
| result_i | input | 12 | Stored conversion result |
| start_o | output | 1 | One-cycle convert-start strobe |
| contention_o | output | 1 | Cycle began with read/convert high |
| data_o | output | 12 | Output data bus |
| data_oe_o | output | 12 | Per-bit driver enable |

## Verification
The hardest situation to reach is a convert condition that begins while the sequencer is still busy. The bench must then confirm that the suppressed start is lost rather than deferred after busy drops, while the condition is still held. Random stimulus rarely holds a convert level across a busy window long enough to show this. A directed sequence therefore opens a convert with busy high, releases busy while keeping the condition steady, and expects silence. Random cycles with biased enables then cover the formats, the edge sources for starts, and the contention pulse. Each cycle is checked against a bench model of the previous-edge state.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;
  typedef enum logic [1:0] {
    FMT_IDLE = 2'd0,
    FMT_WORD = 2'd1,
    FMT_HI   = 2'd2,
    FMT_LO   = 2'd3
  } fmt_e;
endpackage

// File: rtl/adc_cmd_decode.sv
module adc_cmd_decode
  import adc_bus_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic cs_ni,
  input  logic rd_cvt_i,
  input  logic addr_i,
  input  logic wide_i,
  input  logic busy_i,
  output fmt_e fmt_o,
  output logic start_o,
  output logic contention_o
);
  logic active, cvt, rd_now;
  logic active_q, cvt_q, start_q, cont_q;

  assign active = ce_i & ~cs_ni;
  assign cvt    = active & ~rd_cvt_i;
  assign rd_now = active & rd_cvt_i & ~busy_i;

  always_comb begin
    if (!rd_now)     fmt_o = FMT_IDLE;
    else if (wide_i) fmt_o = FMT_WORD;
    else if (addr_i) fmt_o = FMT_LO;
    else             fmt_o = FMT_HI;
  end

  // start only on the edge where the convert condition appears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cvt_q    <= 1'b0;
      start_q  <= 1'b0;
      cont_q   <= 1'b0;
    end else begin
      active_q <= active;
      cvt_q    <= cvt;
      start_q  <= cvt & ~cvt_q & ~busy_i;
      cont_q   <= active & ~active_q & rd_cvt_i;
    end
  end

  assign start_o      = start_q;
  assign contention_o = cont_q;
endmodule

// File: rtl/adc_out_format.sv
module adc_out_format
  import adc_bus_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  fmt_e             fmt_i,
  input  logic [RES_W-1:0] result_i,
  output logic [RES_W-1:0] data_o,
  output logic [RES_W-1:0] oe_o
);
  localparam int LSB_W = RES_W - BYTE_W;
  localparam int PAD_W = BYTE_W - LSB_W;

  logic [BYTE_W-1:0] lo_byte;
  logic [RES_W-1:0]  data_d, oe_d;

  generate
    if (PAD_W > 0) begin : g_pad
      assign lo_byte = {result_i[LSB_W-1:0], {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign lo_byte = result_i[LSB_W-1:0];
    end
  endgenerate

  always_comb begin
    data_d = '0;
    oe_d   = '0;
    unique case (fmt_i)
      FMT_WORD: begin
        data_d = result_i;
        oe_d   = '1;
      end
      FMT_HI: begin
        data_d[RES_W-1 -: BYTE_W] = result_i[RES_W-1 -: BYTE_W];
        oe_d[RES_W-1 -: BYTE_W]   = '1;
      end
      FMT_LO: begin
        data_d[RES_W-1 -: BYTE_W] = lo_byte;
        oe_d[RES_W-1 -: BYTE_W]   = '1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      oe_o   <= '0;
    end else begin
      data_o <= data_d;
      oe_o   <= oe_d;
    end
  end
endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
  import adc_bus_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             cs_ni,
  input  logic             rd_cvt_i,
  input  logic             addr_i,
  input  logic             wide_i,
  input  logic             busy_i,
  input  logic [RES_W-1:0] result_i,
  output logic             start_o,
  output logic             contention_o,
  output logic [RES_W-1:0] data_o,
  output logic [RES_W-1:0] data_oe_o
);
  fmt_e fmt;

  adc_cmd_decode i_decode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ce_i         (ce_i),
    .cs_ni        (cs_ni),
    .rd_cvt_i     (rd_cvt_i),
    .addr_i       (addr_i),
    .wide_i       (wide_i),
    .busy_i       (busy_i),
    .fmt_o        (fmt),
    .start_o      (start_o),
    .contention_o (contention_o)
  );

  adc_out_format #(.RES_W(RES_W), .BYTE_W(BYTE_W)) i_format (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fmt_i    (fmt),
    .result_i (result_i),
    .data_o   (data_o),
    .oe_o     (data_oe_o)
  );
endmodule

// File: rtl/adc_bus_ctrl_chk.sv
module adc_bus_ctrl_chk #(
  parameter int RES_W  = 12,
  parameter int BYTE_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce_i,
  input logic             cs_ni,
  input logic             rd_cvt_i,
  input logic             busy_i,
  input logic             start_o,
  input logic             contention_o,
  input logic [RES_W-1:0] data_o,
  input logic [RES_W-1:0] data_oe_o
);
  localparam logic [RES_W-1:0] HI_MASK = {{BYTE_W{1'b1}}, {(RES_W-BYTE_W){1'b0}}};

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o == '0) |-> (data_o == '0)); // R1
  AST_READ_NEEDS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o != '0) |-> $past(ce_i & ~cs_ni & rd_cvt_i)); // R1
  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R3
  AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !start_o); // R4
  AST_START_NEEDS_CVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(ce_i & ~cs_ni & ~rd_cvt_i)); // R2
  AST_OE_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o == '0) || (data_oe_o == '1) || (data_oe_o == HI_MASK)); // R6
  AST_BUSY_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (data_oe_o == '0)); // R8
  AST_CONTENTION_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    contention_o |-> ($past(rd_cvt_i) && $past(ce_i & ~cs_ni))); // R9
endmodule

bind adc_bus_ctrl adc_bus_ctrl_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ce_i         (ce_i),
  .cs_ni        (cs_ni),
  .rd_cvt_i     (rd_cvt_i),
  .busy_i       (busy_i),
  .start_o      (start_o),
  .contention_o (contention_o),
  .data_o       (data_o),
  .data_oe_o    (data_oe_o)
);

// File: tb/test_adc_bus_ctrl.sv
module test_adc_bus_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b0, cs_n = 1'b1, rd = 1'b1, addr = 1'b0, wide = 1'b0, busy = 1'b0;
  logic [11:0] result = '0;
  logic        start, cont;
  logic [11:0] data, oe;

  int checks = 0;
  int errors = 0;
  logic m_active = 1'b0, m_cvt = 1'b0;
  logic e_start, e_cont;
  logic [11:0] e_data, e_oe;

  always #10 clk = ~clk;

  adc_bus_ctrl i_adc_bus_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .cs_ni(cs_n), .rd_cvt_i(rd),
    .addr_i(addr), .wide_i(wide), .busy_i(busy), .result_i(result),
    .start_o(start), .contention_o(cont), .data_o(data), .data_oe_o(oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string fmt_tag(input logic a, input logic r, input logic b,
                                    input logic w, input logic ad);
    if (!a || !r) return "R1";
    if (b)        return "R8";
    if (w)        return "R5";
    return ad ? "R7" : "R6";
  endfunction

  // one cycle: inputs already driven at negedge; compute expectation, clock, compare
  task automatic step();
    logic a, c;
    string tag;
    a = ce & ~cs_n;
    c = a & ~rd;
    e_start = c & ~m_cvt & ~busy;
    e_cont  = a & ~m_active & rd;
    e_data = '0; e_oe = '0;
    if (a && rd && !busy) begin
      if (wide)      begin e_data = result; e_oe = '1; end
      else if (addr) begin e_data = {result[3:0], 8'h00}; e_oe = 12'hFF0; end
      else           begin e_data = {result[11:4], 4'h0}; e_oe = 12'hFF0; end
    end
    tag = fmt_tag(a, rd, busy, wide, addr);
    m_active = a;
    m_cvt = c;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " oe"}, 32'(oe), 32'(e_oe));
    chk({tag, " data"}, 32'(data), 32'(e_data));
    chk(busy ? "R4 start" : "R2 start", 32'(start), 32'(e_start));
    chk("R9 contention", 32'(cont), 32'(e_cont));
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1 reset oe", 32'(oe), 32'h0);
    chk("R1 reset start", 32'(start), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: convert held several cycles via cs falling
    ce = 1; rd = 0; result = 12'hA5C; step();
    cs_n = 0; step();
    chk("R2 start via cs", 32'(start), 32'h1);
    step(); step();
    chk("R3 held convert", 32'(start), 32'h0);
    // start via rd falling after a read
    rd = 1; step(); rd = 0; step();
    chk("R2 start via rd fall", 32'(start), 32'h1);

    // R4: convert begins while busy, busy released, condition held
    cs_n = 1; step();
    busy = 1; cs_n = 0; step();
    chk("R4 busy suppress", 32'(start), 32'h0);
    busy = 0; step(); step();
    chk("R4 not deferred", 32'(start), 32'h0);

    // R9: cycle opens with rd high
    cs_n = 1; rd = 1; step();
    cs_n = 0; wide = 0; addr = 1; step();
    chk("R9 contention pulse", 32'(cont), 32'h1);
    chk("R7 low byte", 32'(data), 32'hC00);
    addr = 0; step();
    chk("R6 high byte", 32'(data), 32'hA50);

    // R10 / R8: stand-alone low pulse
    ce = 1; cs_n = 0; wide = 1; addr = 0; rd = 1; result = 12'h3E7; step();
    chk("R10 stand-alone drive", 32'(oe), 32'hFFF);
    rd = 0; step();
    chk("R10 start on fall", 32'(start), 32'h1);
    chk("R10 drivers off", 32'(oe), 32'h0);
    busy = 1; rd = 1; step(); step();
    chk("R8 held off while busy", 32'(oe), 32'h0);
    busy = 0; step();
    chk("R8 driven after busy", 32'(data), 32'h3E7);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      ce     = ($urandom % 4) != 0;
      cs_n   = ($urandom % 4) == 0;
      rd     = $urandom % 2;
      addr   = $urandom % 2;
      wide   = $urandom % 2;
      busy   = ($urandom % 5) == 0;
      result = 12'($urandom);
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule